// File: doc/BRIEF.md
# Fixed-Vector Interrupt Priority Controller

This block is the interrupt front end of a small 8-bit processor core. It watches five hardware request lines: a non-maskable request, an edge-latched maskable request, two level-sensitive maskable requests and an externally vectored request. At each instruction boundary strobe from the core it picks at most one winner by fixed priority. It then reports that winner's source together with a 16-bit service address.

Three requests have fixed service addresses. These sit halfway between the 8-byte restart slots. The non-maskable request also has a half-slot address. The externally vectored request has no address of its own. For it, the block raises an opcode strobe and takes one byte from the interrupting device. A restart opcode in that byte is turned into its slot address. A small control register holds three per-source mask bits and a global enable. Software updates it through a mask-write port, and a read-back byte shows the masks, the enable, the pending state and the serial input pin.

Top module: `fixvec_intc`

## Requirements
- R1: Priority, highest first, is: non-maskable, top (edge-latched), mid (level), low (level), external. One boundary strobe yields at most one acknowledge, and `ack_valid` and `ext_ack` are never high together.
- R2: The non-maskable request ignores all mask bits and the global enable. A rising edge on `nmi_pin` is latched one clock later. The latch is recognised at a boundary only if the pin is still high there. The latch is dropped when the pin goes low or when the request is acknowledged.
- R3: A mask write with `msk_wdata[3]=1` loads the masks from `msk_wdata[2:0]` as {top, mid, low}, where 1 means masked. A write with `msk_wdata[3]=0` leaves the masks unchanged. A masked source is never acknowledged.
- R4: A fixed-vector win at a boundary gives `ack_valid` high for one cycle in the next clock, with `ack_fixed=1`. The vectors are: non-maskable 0x0024, top 0x003C, mid 0x0034, low 0x002C. The `ack_src` codes are 1 = non-maskable, 2 = top, 3 = mid, 4 = low, 5 = external.
- R5: The mid and low requests are level-sensitive. They compete only if their pin is high in the boundary cycle, and nothing about them is stored.
- R6: A rising edge on `top_pin` sets a pending latch one clock later, even while the top source is masked. The latch stays set until the top source is acknowledged or a mask write with `msk_wdata[4]=1` clears it.
- R7: An external win gives `ext_ack` high for one cycle in the next clock. `ext_opcode` is sampled in that cycle, and `ack_valid` follows one clock later with `ack_src=5`. If the opcode has the form 11nnn111, the vector is n×8 and `ack_fixed=1`. Any other opcode gives vector 0 with `ack_fixed=0`.
- R8: `mask_rd` is laid out as: bit 7 serial input, bit 6 top pending, bit 5 mid pin, bit 4 low pin, bit 3 global enable, bits 2:0 masks {top, mid, low}.
- R9: Reset leaves all masks set, the enable clear and nothing pending. `ie_set` sets the enable and `ie_clr` clears it. Every acknowledge decision, including a non-maskable one, clears the enable, and this wins over `ie_set` in the same cycle. The enable gates every maskable source, the external one included.
- R10: Boundary strobes that arrive while the block is waiting for an external opcode are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| boundary | input | 1 | Instruction boundary strobe; requests are sampled here |
| nmi_pin | input | 1 | Non-maskable request |
| top_pin | input | 1 | Edge-latched maskable request |
| mid_pin | input | 1 | Level-sensitive maskable request, middle priority |
| low_pin | input | 1 | Level-sensitive maskable request, lower priority |
| ext_pin | input | 1 | Externally vectored request |
| serial_in | input | 1 | Serial input pin, reported in read-back |
| msk_wr | input | 1 | Mask-write strobe |
| msk_wdata | input | 5 | Mask-write data: [4] clear top pending, [3] apply masks, [2:0] masks |
| ie_set | input | 1 | Set global enable |
| ie_clr | input | 1 | Clear global enable |
| ext_opcode | input | 8 | Opcode byte supplied by the external device |
| ext_ack | output | 1 | Opcode request strobe for the external source |
| ack_valid | output | 1 | Acknowledge pulse |
| ack_src | output | 3 | Acknowledged source code |
| ack_vector | output | 16 | Service address |
| ack_fixed | output | 1 | Vector is meaningful |
| mask_rd | output | 8 | Read-back byte |

## Verification
Most internal state in this block is visible at the ports. If the top pending latch or the enable is wrong, `mask_rd` shows it one clock after the update that caused it. If the non-maskable latch or the opcode-wait state is wrong, nothing shows until the next boundary strobe. From that strobe, the error appears within one clock as a missing, extra or misattributed acknowledge, or within two clocks on the external path. Because the bench compares every port on every cycle, a state error is reported at the first cycle in which it changes an output.

// File: rtl/fvi_pkg.sv
package fvi_pkg;

    localparam int VEC_W      = 16;
    localparam int RST_STRIDE = 8;
    localparam int MW_APPLY   = 3;
    localparam int MW_CLR_TOP = 4;
    localparam int MW_W       = MW_CLR_TOP + 1;

    // half-step slot indices: vector = slot*stride + stride/2
    localparam int SLOT_NMI = 4;
    localparam int SLOT_LOW = 5;
    localparam int SLOT_MID = 6;
    localparam int SLOT_TOP = 7;

    typedef enum logic [2:0] {
        SRC_NONE = 3'd0,
        SRC_NMI  = 3'd1,
        SRC_TOP  = 3'd2,
        SRC_MID  = 3'd3,
        SRC_LOW  = 3'd4,
        SRC_EXT  = 3'd5
    } src_e;

    typedef struct packed {
        logic nmi;
        logic top;
        logic mid;
        logic low;
        logic ext;
    } req_t;

    function automatic logic [VEC_W-1:0] half_vec(input int unsigned slot);
        return VEC_W'(slot * RST_STRIDE + RST_STRIDE / 2);
    endfunction

    function automatic logic [VEC_W-1:0] restart_vec(input logic [2:0] n);
        return VEC_W'(n) * VEC_W'(RST_STRIDE);
    endfunction

    function automatic logic is_restart(input logic [7:0] op);
        return (op[7:6] == 2'b11) && (op[2:0] == 3'b111);
    endfunction

    function automatic logic [VEC_W-1:0] fixed_vec(input src_e s);
        case (s)
            SRC_NMI: return half_vec(SLOT_NMI);
            SRC_TOP: return half_vec(SLOT_TOP);
            SRC_MID: return half_vec(SLOT_MID);
            SRC_LOW: return half_vec(SLOT_LOW);
            default: return '0;
        endcase
    endfunction

endpackage

// File: rtl/fvi_capture.sv
module fvi_capture #(
    parameter bit HOLD_HIGH = 1'b0
) (
    input  logic clk,
    input  logic rst,
    input  logic pin,
    input  logic clr,
    output logic pend
);
    logic prev_q;
    logic pend_q;
    logic drop;

    generate
        if (HOLD_HIGH) begin : g_hold
            assign drop = clr || !pin;
        end else begin : g_latch
            assign drop = clr;
        end
    endgenerate

    always_ff @(posedge clk) begin
        if (rst) begin
            prev_q <= 1'b0;
            pend_q <= 1'b0;
        end else begin
            prev_q <= pin;
            if (pin && !prev_q)
                pend_q <= 1'b1;
            else if (drop)
                pend_q <= 1'b0;
        end
    end

    assign pend = pend_q;
endmodule

// File: rtl/fvi_mask_ctl.sv
module fvi_mask_ctl
    import fvi_pkg::*;
(
    input  logic            clk,
    input  logic            rst,
    input  logic            wr,
    input  logic [MW_W-1:0] wdata,
    input  logic            ie_set,
    input  logic            ie_clr,
    input  logic            ack,
    output logic [2:0]      mask,
    output logic            ie,
    output logic            top_clr
);
    logic [2:0] mask_q;
    logic       ie_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            mask_q <= 3'b111;
            ie_q   <= 1'b0;
        end else begin
            if (wr && wdata[MW_APPLY])
                mask_q <= wdata[2:0];
            if (ack || ie_clr)
                ie_q <= 1'b0;
            else if (ie_set)
                ie_q <= 1'b1;
        end
    end

    assign mask    = mask_q;
    assign ie      = ie_q;
    assign top_clr = wr && wdata[MW_CLR_TOP];
endmodule

// File: rtl/fvi_arbiter.sv
module fvi_arbiter
    import fvi_pkg::*;
(
    input  req_t req,
    output src_e win
);
    localparam int N = $bits(req_t);
    logic [N-1:0] vec;
    src_e         code [N];

    assign vec = req;

    // index 0 is lowest priority (ext), N-1 highest (nmi)
    assign code[0] = SRC_EXT;
    assign code[1] = SRC_LOW;
    assign code[2] = SRC_MID;
    assign code[3] = SRC_TOP;
    assign code[4] = SRC_NMI;

    always_comb begin
        win = SRC_NONE;
        for (int i = 0; i < N; i++) begin
            if (vec[i])
                win = code[i];
        end
    end
endmodule

// File: rtl/fixvec_intc.sv
module fixvec_intc
    import fvi_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             boundary,
    input  logic             nmi_pin,
    input  logic             top_pin,
    input  logic             mid_pin,
    input  logic             low_pin,
    input  logic             ext_pin,
    input  logic             serial_in,
    input  logic             msk_wr,
    input  logic [MW_W-1:0]  msk_wdata,
    input  logic             ie_set,
    input  logic             ie_clr,
    input  logic [7:0]       ext_opcode,
    output logic             ext_ack,
    output logic             ack_valid,
    output logic [2:0]       ack_src,
    output logic [VEC_W-1:0] ack_vector,
    output logic             ack_fixed,
    output logic [7:0]       mask_rd
);
    typedef enum logic {ST_IDLE, ST_FETCH} st_e;

    st_e              st_q;
    logic             nmi_pend;
    logic             top_pend;
    logic             top_wclr;
    logic [2:0]       mask;
    logic             ie;
    req_t             req;
    src_e             win;
    logic             go;
    logic             valid_q;
    logic             extack_q;
    logic             fixed_q;
    src_e             src_q;
    logic [VEC_W-1:0] vec_q;

    fvi_capture #(.HOLD_HIGH(1'b1)) u_nmi_cap (
        .clk  (clk),
        .rst  (rst),
        .pin  (nmi_pin),
        .clr  (go && (win == SRC_NMI)),
        .pend (nmi_pend)
    );

    fvi_capture #(.HOLD_HIGH(1'b0)) u_top_cap (
        .clk  (clk),
        .rst  (rst),
        .pin  (top_pin),
        .clr  ((go && (win == SRC_TOP)) || top_wclr),
        .pend (top_pend)
    );

    fvi_mask_ctl u_mask (
        .clk     (clk),
        .rst     (rst),
        .wr      (msk_wr),
        .wdata   (msk_wdata),
        .ie_set  (ie_set),
        .ie_clr  (ie_clr),
        .ack     (go),
        .mask    (mask),
        .ie      (ie),
        .top_clr (top_wclr)
    );

    always_comb begin
        req.nmi = nmi_pend && nmi_pin;
        req.top = top_pend && !mask[2] && ie;
        req.mid = mid_pin  && !mask[1] && ie;
        req.low = low_pin  && !mask[0] && ie;
        req.ext = ext_pin  && ie;
    end

    fvi_arbiter u_arb (
        .req (req),
        .win (win)
    );

    assign go = boundary && (st_q == ST_IDLE) && (win != SRC_NONE);

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q     <= ST_IDLE;
            valid_q  <= 1'b0;
            extack_q <= 1'b0;
            fixed_q  <= 1'b0;
            src_q    <= SRC_NONE;
            vec_q    <= '0;
        end else begin
            valid_q  <= 1'b0;
            extack_q <= 1'b0;
            if (st_q == ST_FETCH) begin
                st_q    <= ST_IDLE;
                valid_q <= 1'b1;
                src_q   <= SRC_EXT;
                if (is_restart(ext_opcode)) begin
                    vec_q   <= restart_vec(ext_opcode[5:3]);
                    fixed_q <= 1'b1;
                end else begin
                    vec_q   <= '0;
                    fixed_q <= 1'b0;
                end
            end else if (go) begin
                if (win == SRC_EXT) begin
                    extack_q <= 1'b1;
                    st_q     <= ST_FETCH;
                end else begin
                    valid_q <= 1'b1;
                    src_q   <= win;
                    vec_q   <= fixed_vec(win);
                    fixed_q <= 1'b1;
                end
            end
        end
    end

    assign ext_ack    = extack_q;
    assign ack_valid  = valid_q;
    assign ack_src    = src_q;
    assign ack_vector = vec_q;
    assign ack_fixed  = fixed_q;
    assign mask_rd    = {serial_in, top_pend, mid_pin, low_pin, ie, mask};
endmodule

// File: rtl/fvi_chk.sv
module fvi_chk
    import fvi_pkg::*;
(
    input logic             clk,
    input logic             rst,
    input logic             nmi_pin,
    input logic             top_pin,
    input logic             ext_ack,
    input logic             ack_valid,
    input logic [2:0]       ack_src,
    input logic [VEC_W-1:0] ack_vector,
    input logic             ack_fixed,
    input logic [7:0]       mask_rd
);
    // R1
    single_ack_chk: assert property (@(posedge clk) disable iff (rst)
        !(ack_valid && ext_ack));

    // R2
    nmi_held_chk: assert property (@(posedge clk) disable iff (rst)
        (ack_valid && ack_src == SRC_NMI) |-> $past(nmi_pin));

    // R4
    nmi_vector_chk: assert property (@(posedge clk) disable iff (rst)
        (ack_valid && ack_src == SRC_NMI) |-> (ack_vector == 16'h0024 && ack_fixed));

    // R4
    top_vector_chk: assert property (@(posedge clk) disable iff (rst)
        (ack_valid && ack_src == SRC_TOP) |-> (ack_vector == 16'h003C && ack_fixed));

    // R6
    top_pend_rise_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(mask_rd[6]) |-> $past(top_pin));

    // R7
    ext_follow_chk: assert property (@(posedge clk) disable iff (rst)
        ext_ack |=> (ack_valid && ack_src == SRC_EXT));

    // R9
    ie_cleared_chk: assert property (@(posedge clk) disable iff (rst)
        ((ack_valid && ack_src != SRC_EXT) || ext_ack) |-> !mask_rd[3]);

    // R10
    ext_single_chk: assert property (@(posedge clk) disable iff (rst)
        ext_ack |=> !ext_ack);
endmodule

bind fixvec_intc fvi_chk u_fvi_chk (
    .clk        (clk),
    .rst        (rst),
    .nmi_pin    (nmi_pin),
    .top_pin    (top_pin),
    .ext_ack    (ext_ack),
    .ack_valid  (ack_valid),
    .ack_src    (ack_src),
    .ack_vector (ack_vector),
    .ack_fixed  (ack_fixed),
    .mask_rd    (mask_rd)
);

// File: tb/fixvec_intc_tb_top.sv
module fixvec_intc_tb_top;
    import fvi_pkg::*;

    logic clk = 1'b0;
    always #5 clk = ~clk;

    logic        rst = 1'b1;
    logic        boundary = 0, nmi_pin = 0, top_pin = 0, mid_pin = 0, low_pin = 0, ext_pin = 0;
    logic        serial_in = 0, msk_wr = 0, ie_set = 0, ie_clr = 0;
    logic [4:0]  msk_wdata = '0;
    logic [7:0]  ext_opcode = '0;
    logic        ext_ack, ack_valid, ack_fixed;
    logic [2:0]  ack_src;
    logic [15:0] ack_vector;
    logic [7:0]  mask_rd;

    fixvec_intc dut_i (
        .clk(clk), .rst(rst), .boundary(boundary), .nmi_pin(nmi_pin), .top_pin(top_pin),
        .mid_pin(mid_pin), .low_pin(low_pin), .ext_pin(ext_pin), .serial_in(serial_in),
        .msk_wr(msk_wr), .msk_wdata(msk_wdata), .ie_set(ie_set), .ie_clr(ie_clr),
        .ext_opcode(ext_opcode), .ext_ack(ext_ack), .ack_valid(ack_valid), .ack_src(ack_src),
        .ack_vector(ack_vector), .ack_fixed(ack_fixed), .mask_rd(mask_rd)
    );

    int n_cmp = 0;
    int n_bad = 0;
    bit done = 0;

    // reference state from the requirements
    logic [2:0]  m_mask = 3'b111;
    logic        m_ie = 0, m_tpend = 0, m_npend = 0, m_nprev = 0, m_tprev = 0, m_fetch = 0;
    logic        e_valid, e_ext, e_fixed;
    logic [2:0]  e_src;
    logic [15:0] e_vec;
    logic [7:0]  e_rd;

    function automatic logic [15:0] exp_vec(input logic [2:0] s);
        case (s)
            3'd1: return 16'h0024;
            3'd2: return 16'h003C;
            3'd3: return 16'h0034;
            3'd4: return 16'h002C;
            default: return 16'h0000;
        endcase
    endfunction

    task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        n_cmp++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic model_step();
        logic [2:0] w;
        logic acked;
        w = 3'd0;
        acked = 0;
        e_valid = 0;
        e_ext = 0;
        if (m_fetch) begin
            e_valid = 1;
            e_src = 3'd5;
            if (ext_opcode[7:6] == 2'b11 && ext_opcode[2:0] == 3'b111) begin
                e_vec = {10'd0, ext_opcode[5:3], 3'd0};
                e_fixed = 1;
            end else begin
                e_vec = 16'd0;
                e_fixed = 0;
            end
            m_fetch = 0;
        end else if (boundary) begin
            if (m_npend && nmi_pin)                   w = 3'd1;
            else if (m_tpend && !m_mask[2] && m_ie)   w = 3'd2;
            else if (mid_pin && !m_mask[1] && m_ie)   w = 3'd3;
            else if (low_pin && !m_mask[0] && m_ie)   w = 3'd4;
            else if (ext_pin && m_ie)                 w = 3'd5;
            if (w != 3'd0) begin
                acked = 1;
                if (w == 3'd5) begin
                    e_ext = 1;
                    m_fetch = 1;
                end else begin
                    e_valid = 1;
                    e_src = w;
                    e_vec = exp_vec(w);
                    e_fixed = 1;
                end
            end
        end
        if (nmi_pin && !m_nprev) m_npend = 1;
        else if (!nmi_pin || (acked && w == 3'd1)) m_npend = 0;
        if (top_pin && !m_tprev) m_tpend = 1;
        else if ((acked && w == 3'd2) || (msk_wr && msk_wdata[4])) m_tpend = 0;
        if (msk_wr && msk_wdata[3]) m_mask = msk_wdata[2:0];
        if (acked || ie_clr) m_ie = 0;
        else if (ie_set) m_ie = 1;
        m_nprev = nmi_pin;
        m_tprev = top_pin;
        e_rd = {serial_in, m_tpend, mid_pin, low_pin, m_ie, m_mask};
    endtask

    task automatic tick();
        model_step();
        @(posedge clk);
        @(negedge clk);
        check(ack_valid == e_valid, "R1 ack_valid", ack_valid, e_valid);
        if (e_valid && ack_valid) begin
            check(ack_src == e_src, "R1 ack_src", ack_src, e_src);
            check(ack_vector == e_vec, "R4 ack_vector", ack_vector, e_vec);
            check(ack_fixed == e_fixed, "R7 ack_fixed", ack_fixed, e_fixed);
        end
        check(ext_ack == e_ext, "R7 ext_ack", ext_ack, e_ext);
        check(mask_rd == e_rd, "R8 mask_rd", mask_rd, e_rd);
        boundary = 0;
        msk_wr = 0;
        ie_set = 0;
        ie_clr = 0;
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog expired actual=0 expected=1");
        finish_run();
    end

    initial begin
        void'($urandom(32'd20240611));
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 0;
        @(posedge clk);
        @(negedge clk);
        // R9 reset state
        check(mask_rd == 8'h07, "R9 reset read-back", mask_rd, 8'h07);
        check(!ack_valid && !ext_ack, "R9 no ack after reset", {ack_valid, ext_ack}, 0);

        // R2 non-maskable passes masks and disabled enable
        nmi_pin = 1; tick();
        boundary = 1; tick();
        check(ack_valid && ack_src == 3'd1 && ack_vector == 16'h0024, "R2 nmi through masks", ack_vector, 16'h0024);
        nmi_pin = 0; tick();
        // R2 pulse dropped before boundary
        nmi_pin = 1; tick();
        nmi_pin = 0; tick();
        boundary = 1; tick();
        check(!ack_valid, "R2 dropped nmi not taken", ack_valid, 0);

        // R3 write without apply bit keeps masks
        msk_wr = 1; msk_wdata = 5'b00000; tick();
        check(mask_rd[2:0] == 3'b111, "R3 no apply", mask_rd[2:0], 3'b111);
        msk_wr = 1; msk_wdata = 5'b01000; tick();
        check(mask_rd[2:0] == 3'b000, "R3 apply", mask_rd[2:0], 3'b000);

        // R9 enable gates maskables
        mid_pin = 1; boundary = 1; tick();
        check(!ack_valid && !ext_ack, "R9 disabled gates mid", ack_valid, 0);
        ie_set = 1; tick();
        check(mask_rd[3], "R9 ie set", mask_rd[3], 1);

        // R1 priority ladder
        top_pin = 1; low_pin = 1; ext_pin = 1; tick();
        boundary = 1; tick();
        check(ack_valid && ack_src == 3'd2 && ack_vector == 16'h003C, "R1 top wins", ack_src, 2);
        check(!mask_rd[3], "R9 ie cleared by ack", mask_rd[3], 0);
        check(!mask_rd[6], "R6 pend cleared by ack", mask_rd[6], 0);
        boundary = 1; tick();
        check(!ack_valid && !ext_ack, "R9 nothing while disabled", ack_valid, 0);
        ie_set = 1; tick();
        boundary = 1; tick();
        check(ack_valid && ack_src == 3'd3 && ack_vector == 16'h0034, "R1 mid beats low", ack_src, 3);
        ie_set = 1; mid_pin = 0; tick();
        boundary = 1; tick();
        check(ack_valid && ack_src == 3'd4 && ack_vector == 16'h002C, "R5 low level taken", ack_src, 4);
        ie_set = 1; low_pin = 0; tick();
        // R7 external with restart opcode, R10 boundary during fetch
        boundary = 1; nmi_pin = 1; tick();
        check(ext_ack && !ack_valid, "R7 opcode strobe", ext_ack, 1);
        ext_opcode = 8'hEF; boundary = 1; tick();
        check(ack_valid && ack_src == 3'd5 && ack_vector == 16'h0028 && ack_fixed, "R7 restart opcode", ack_vector, 16'h0028);
        tick();
        check(!ack_valid && !ext_ack, "R10 boundary during fetch ignored", ack_valid, 0);
        boundary = 1; tick();
        check(ack_valid && ack_src == 3'd1, "R10 nmi taken later", ack_src, 1);
        nmi_pin = 0; top_pin = 0; tick();

        // R6 edge latched while masked, cleared by write
        msk_wr = 1; msk_wdata = 5'b01100; tick();
        top_pin = 1; tick();
        check(mask_rd[6], "R6 pend while masked", mask_rd[6], 1);
        ie_set = 1; ext_pin = 0; tick();
        boundary = 1; tick();
        check(!ack_valid && !ext_ack, "R3 masked top not taken", ack_valid, 0);
        msk_wr = 1; msk_wdata = 5'b10000; tick();
        check(!mask_rd[6], "R6 cleared by write", mask_rd[6], 0);
        check(mask_rd[2:0] == 3'b100, "R3 masks kept", mask_rd[2:0], 3'b100);

        // R7 non-restart opcode
        ext_pin = 1; boundary = 1; tick();
        ext_opcode = 8'hCD; tick();
        check(ack_valid && !ack_fixed && ack_vector == 16'h0, "R7 non-restart opcode", ack_fixed, 0);
        ext_pin = 0; top_pin = 0; tick();

        // random mix
        for (int i = 0; i < 4000; i++) begin
            boundary   = ($urandom % 10) < 3;
            if ($urandom % 10 == 0) nmi_pin = ~nmi_pin;
            if ($urandom % 6 == 0)  top_pin = ~top_pin;
            mid_pin    = ($urandom % 4) == 0;
            low_pin    = ($urandom % 4) == 0;
            ext_pin    = ($urandom % 3) == 0;
            serial_in  = $urandom % 2;
            msk_wr     = ($urandom % 10) == 0;
            msk_wdata  = 5'($urandom);
            ie_set     = ($urandom % 5) == 0;
            ie_clr     = ($urandom % 20) == 0;
            ext_opcode = ($urandom % 2) ? {2'b11, 3'($urandom), 3'b111} : 8'($urandom);
            tick();
        end
        finish_run();
    end
endmodule